// File: doc/BRIEF.md
# DRAM Burst Fill Controller

This block sits between a processor's cache-line fill requests and a bank of fast-page-mode DRAM. It accepts one request at a time: a longword address, a flag that asks for a four-longword burst or a single longword, and a read/write flag. It then drives row and column strobes, a row address, a wrapping column address, a write strobe and a per-beat acknowledge. The first longword is slow because the row must be opened. The three longwords that follow reuse the open page and arrive faster.

The DRAM window covers byte addresses 20000000h through 2FFFFFFFh. A 3-bit size code reports how much memory is fitted. The installed memory repeats across the window with a period that depends on that size. Parts of each 16 MB slice that hold no memory are blank. A request that lands in a blank region gets no acknowledge. Instead it gets a one-cycle no-response pulse, so that a bus timer elsewhere can end the cycle.

Controller states: `S_IDLE` waits for a request. `S_ROW` and `S_RCD` open the row. `S_CAS` drives the column strobe before data. `S_ACK` is a data beat. `S_CPRE` is the column precharge between beats. `S_BLANK` gives the no-response pulse. Transitions:
- `S_IDLE`→`S_ROW` when the request hits memory.
- `S_IDLE`→`S_BLANK` when the request misses.
- `S_ROW`→`S_RCD`→`S_CAS`→`S_ACK`, unconditionally.
- `S_ACK`→`S_CPRE` while beats remain.
- `S_CPRE`→`S_ACK`.
- `S_ACK`→`S_IDLE` after the last beat.
- `S_BLANK`→`S_IDLE`.

Top module: `dram_fill_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1. `row_strobe`, `col_strobe`, `wr_strobe`, `beat_ack` and `no_resp` are all 0.
- R2: A request whose byte address bits 31..28 are not 2h is blank.
- R3: With size code 000b (4 MB), a request is blank unless byte address bits 23..22 are 00b. With code 001b (8 MB), a request is blank unless bit 23 is 0.
- R4: Codes 010b, 011b and 100b (16, 32, 64 MB) never blank a request inside the window. The physical byte address is the window offset (bits 27..0) modulo the installed size. `row_addr` is physical longword bits 23..10 and `col_addr` is bits 9..0.
- R5: Size codes 101b, 110b and 111b are reserved, and every request made under them is blank.
- R6: A blank request is accepted in the cycle it is presented. `no_resp` is then 1 for exactly the next cycle, and `req_ready` returns 1 in the cycle after that. No strobe or acknowledge is raised.
- R7: For a hit, `row_strobe` rises in the first cycle after acceptance. `col_strobe` is asserted in cycles 3 and 4, and the first `beat_ack` is in cycle 4.
- R8: A burst gives exactly four acknowledges, two cycles apart, in cycles 4, 6, 8 and 10 after acceptance.
- R9: The first beat's `col_addr` is the requested longword. Each later beat adds one to the two low column bits, wrapping within the 16-byte line, and leaves the upper column bits unchanged.
- R10: A single (non-burst) access gives one acknowledge in cycle 4, and `req_ready` returns in cycle 5.
- R11: `row_strobe` and `row_addr` stay constant from cycle 1 through the last beat. `col_strobe` drops for one cycle between beats.
- R12: `wr_strobe` follows `col_strobe` for write requests and stays 0 for reads.
- R13: Requests presented while `req_ready` is 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present; taken when `req_ready` is 1 |
| req_addr | input | 30 | Longword address (byte address bits 31..2) |
| req_burst | input | 1 | 1: four-longword burst, 0: single longword |
| req_write | input | 1 | 1: write, 0: read |
| size_code | input | 3 | Installed size code (000b = 4 MB to 100b = 64 MB) |
| req_ready | output | 1 | Controller idle; a request would be accepted |
| row_strobe | output | 1 | Row strobe, active high |
| col_strobe | output | 1 | Column strobe, active high |
| wr_strobe | output | 1 | Write enable, active high |
| row_addr | output | 14 | DRAM row (physical longword bits 23..10) |
| col_addr | output | 10 | DRAM column (physical longword bits 9..0) |
| beat_ack | output | 1 | One longword transferred this cycle |
| no_resp | output | 1 | One-cycle pulse for a blank access |

## Verification
The checker watches the following on every cycle:
- the column strobe stays inside the row strobe;
- acknowledges and write strobes only appear with the column strobe;
- acknowledges are never adjacent;
- the row strobe falls only after an acknowledge, and the row address stays fixed while it is held;
- the no-response pulse is one cycle long and carries no strobes;
- the column advance with wrap follows every acknowledge that has beats remaining.

Only the bench's scenarios can show the following:
- that the decode picks the right blank regions and alias for each size code;
- the exact beat count and the four-cycle first-beat latency;
- that requests made while busy are dropped.

// File: rtl/dfc_pkg.sv
package dfc_pkg;
    localparam int ADDR_W    = 32;
    localparam int LW_AW     = ADDR_W - 2;
    localparam int WIN_LOG   = 28;
    localparam int TAG_W     = ADDR_W - WIN_LOG;
    localparam int WIN_TAG   = 2;
    localparam int SLICE_LOG = 24;
    localparam int BASE_LOG  = 22;
    localparam int MAX_CODE  = 4;
    localparam int PHYS_LOG  = BASE_LOG + MAX_CODE;
    localparam int PLW_W     = PHYS_LOG - 2;
    localparam int COL_W     = 10;
    localparam int ROW_W     = PLW_W - COL_W;
    localparam int BEATS     = 4;
    localparam int BEAT_W    = $clog2(BEATS);

    typedef enum logic [2:0] {
        S_IDLE,
        S_ROW,
        S_RCD,
        S_CAS,
        S_ACK,
        S_CPRE,
        S_BLANK
    } dfc_state_e;
endpackage

// File: rtl/dfc_win_decode.sv
module dfc_win_decode
    import dfc_pkg::*;
(
    input  logic [LW_AW-1:0] lw_addr,
    input  logic [2:0]       size_code,
    output logic             hit,
    output logic [ROW_W-1:0] row,
    output logic [COL_W-1:0] col
);
    localparam logic [LW_AW-1:0] SLICE_LIM = LW_AW'((64'd1 << (SLICE_LOG - 2)) - 64'd1);

    logic             in_win;
    logic             code_ok;
    logic [LW_AW-1:0] size_lim;
    logic [LW_AW-1:0] hole_mask;
    logic [PLW_W-1:0] phys_lw;

    always_comb begin
        in_win   = (lw_addr[LW_AW-1:WIN_LOG-2] == TAG_W'(WIN_TAG));
        code_ok  = (int'(size_code) <= MAX_CODE);
        size_lim = '0;
        for (int k = 0; k <= MAX_CODE; k++) begin
            if (int'(size_code) == k)
                size_lim = LW_AW'((64'd1 << (BASE_LOG - 2 + k)) - 64'd1);
        end
        hole_mask = SLICE_LIM & ~size_lim;
        hit       = in_win && code_ok && ((lw_addr & hole_mask) == '0);
        phys_lw   = lw_addr[PLW_W-1:0] & size_lim[PLW_W-1:0];
        row       = phys_lw[PLW_W-1:COL_W];
        col       = phys_lw[COL_W-1:0];
    end
endmodule

// File: rtl/dfc_col_seq.sv
module dfc_col_seq
    import dfc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [COL_W-1:0] load_col,
    input  logic             advance,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:BEAT_W] page_col_q;
    logic [BEAT_W-1:0]     beat_col_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_col_q <= '0;
            beat_col_q <= '0;
        end else if (load) begin
            page_col_q <= load_col[COL_W-1:BEAT_W];
            beat_col_q <= load_col[BEAT_W-1:0];
        end else if (advance) begin
            beat_col_q <= beat_col_q + BEAT_W'(1);
        end
    end

    assign col = {page_col_q, beat_col_q};
endmodule

// File: rtl/dram_fill_ctrl.sv
module dram_fill_ctrl
    import dfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [LW_AW-1:0]  req_addr,
    input  logic              req_burst,
    input  logic              req_write,
    input  logic [2:0]        size_code,
    output logic              req_ready,
    output logic              row_strobe,
    output logic              col_strobe,
    output logic              wr_strobe,
    output logic [ROW_W-1:0]  row_addr,
    output logic [COL_W-1:0]  col_addr,
    output logic              beat_ack,
    output logic              no_resp
);
    dfc_state_e        state_q, state_d;
    logic              dec_hit;
    logic [ROW_W-1:0]  dec_row;
    logic [COL_W-1:0]  dec_col;
    logic              accept;
    logic              last_beat;
    logic              col_adv;
    logic [BEAT_W-1:0] beat_q;
    logic              burst_q;
    logic              write_q;
    logic [ROW_W-1:0]  row_q;

    dfc_win_decode u_dec (
        .lw_addr   (req_addr),
        .size_code (size_code),
        .hit       (dec_hit),
        .row       (dec_row),
        .col       (dec_col)
    );

    assign accept    = (state_q == S_IDLE) && req_valid;
    assign last_beat = !burst_q || (beat_q == BEAT_W'(BEATS - 1));
    assign col_adv   = (state_q == S_ACK) && !last_beat;

    dfc_col_seq u_col (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_col (dec_col),
        .advance  (col_adv),
        .col      (col_addr)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (req_valid) state_d = dec_hit ? S_ROW : S_BLANK;
            S_ROW:   state_d = S_RCD;
            S_RCD:   state_d = S_CAS;
            S_CAS:   state_d = S_ACK;
            S_ACK:   state_d = last_beat ? S_IDLE : S_CPRE;
            S_CPRE:  state_d = S_ACK;
            S_BLANK: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // request capture and beat count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q  <= '0;
            burst_q <= 1'b0;
            write_q <= 1'b0;
            row_q   <= '0;
        end else if (accept) begin
            beat_q  <= '0;
            burst_q <= req_burst;
            write_q <= req_write;
            row_q   <= dec_row;
        end else if (col_adv) begin
            beat_q  <= beat_q + BEAT_W'(1);
        end
    end

    // outputs decoded from state
    always_comb begin
        req_ready  = 1'b0;
        row_strobe = 1'b0;
        col_strobe = 1'b0;
        beat_ack   = 1'b0;
        no_resp    = 1'b0;
        unique case (state_q)
            S_IDLE:  req_ready = 1'b1;
            S_ROW,
            S_RCD,
            S_CPRE:  row_strobe = 1'b1;
            S_CAS: begin
                row_strobe = 1'b1;
                col_strobe = 1'b1;
            end
            S_ACK: begin
                row_strobe = 1'b1;
                col_strobe = 1'b1;
                beat_ack   = 1'b1;
            end
            S_BLANK: no_resp = 1'b1;
            default: req_ready = 1'b0;
        endcase
        wr_strobe = col_strobe && write_q;
        row_addr  = row_q;
    end
endmodule

// File: rtl/dfc_checker.sv
module dfc_checker
    import dfc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             row_strobe,
    input logic             col_strobe,
    input logic             wr_strobe,
    input logic             beat_ack,
    input logic             no_resp,
    input logic [ROW_W-1:0] row_addr,
    input logic [COL_W-1:0] col_addr
);
    a_r11_col_inside_row: assert property (@(posedge clk) disable iff (!rst_n)
        col_strobe |-> row_strobe);

    a_r7_ack_needs_col: assert property (@(posedge clk) disable iff (!rst_n)
        beat_ack |-> col_strobe);

    a_r12_write_needs_col: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |-> col_strobe);

    a_r6_blank_silent: assert property (@(posedge clk) disable iff (!rst_n)
        no_resp |-> (!row_strobe && !beat_ack && !req_ready));

    a_r6_blank_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        no_resp |=> !no_resp);

    a_r8_ack_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        beat_ack |=> !beat_ack);

    a_r11_row_ends_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(row_strobe) |-> $past(beat_ack));

    a_r11_row_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (row_strobe && $past(row_strobe)) |-> $stable(row_addr));

    a_r9_col_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        beat_ack |=> (!row_strobe ||
            ((col_addr[BEAT_W-1:0] == $past(col_addr[BEAT_W-1:0]) + BEAT_W'(1)) &&
             (col_addr[COL_W-1:BEAT_W] == $past(col_addr[COL_W-1:BEAT_W])))));

    a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!row_strobe && !no_resp));
endmodule

bind dram_fill_ctrl dfc_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .row_strobe (row_strobe),
    .col_strobe (col_strobe),
    .wr_strobe  (wr_strobe),
    .beat_ack   (beat_ack),
    .no_resp    (no_resp),
    .row_addr   (row_addr),
    .col_addr   (col_addr)
);

// File: tb/sim_dram_fill_ctrl.sv
module sim_dram_fill_ctrl;
    import dfc_pkg::*;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [LW_AW-1:0] req_addr = '0;
    logic             req_burst = 1'b0;
    logic             req_write = 1'b0;
    logic [2:0]       size_code = '0;
    logic             req_ready, row_strobe, col_strobe, wr_strobe, beat_ack, no_resp;
    logic [ROW_W-1:0] row_addr;
    logic [COL_W-1:0] col_addr;

    always #2.5 clk = ~clk;

    dram_fill_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_burst(req_burst), .req_write(req_write), .size_code(size_code),
        .req_ready(req_ready), .row_strobe(row_strobe), .col_strobe(col_strobe),
        .wr_strobe(wr_strobe), .row_addr(row_addr), .col_addr(col_addr),
        .beat_ack(beat_ack), .no_resp(no_resp)
    );

    typedef struct {
        bit ras, cas, ack, nr, wr;
        int row, col;
    } exp_t;

    exp_t  sched[$];
    bit    idle_now = 1'b1;
    int    vectors = 0;
    int    miscompares = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    function automatic exp_t mk(bit ras, bit cas, bit ack, bit nr, bit wr, int row, int col);
        exp_t e;
        e.ras = ras; e.cas = cas; e.ack = ack; e.nr = nr; e.wr = wr;
        e.row = row; e.col = col;
        return e;
    endfunction

    // behavioural reference: decode and per-cycle schedule of one request
    function automatic void plan_request();
        longint b     = longint'({req_addr, 2'b00});
        longint sz    = 64'h40_0000 << size_code;
        longint slice = 64'h100_0000;
        longint off   = b & 64'h0FFF_FFFF;
        bit     blank = ((b >> 28) != 2) || (size_code > 3'd4);
        longint lw;
        int     row, cbase, s, beats;
        if (!blank && sz < slice && (off % slice) >= sz) blank = 1'b1;
        if (blank) begin
            sched.push_back(mk(0, 0, 0, 1, 0, 0, 0));
            return;
        end
        lw    = (off % sz) / 4;
        row   = int'(lw / 1024);
        cbase = int'(lw % 1024) & ~3;
        s     = int'(lw % 4);
        beats = req_burst ? 4 : 1;
        sched.push_back(mk(1, 0, 0, 0, 0, row, 0));
        sched.push_back(mk(1, 0, 0, 0, 0, row, 0));
        sched.push_back(mk(1, 1, 0, 0, req_write, row, cbase + s));
        sched.push_back(mk(1, 1, 1, 0, req_write, row, cbase + s));
        for (int k = 1; k < beats; k++) begin
            sched.push_back(mk(1, 0, 0, 0, 0, row, 0));
            sched.push_back(mk(1, 1, 1, 0, req_write, row, cbase + ((s + k) % 4)));
        end
    endfunction

    task automatic chk(string what, int act, int exp_v);
        if (act != exp_v) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, exp_v, $time);
        end
    endtask

    task automatic compare();
        exp_t e;
        if (sched.size() > 0) begin
            e = sched.pop_front();
            idle_now = 1'b0;
        end else begin
            e = mk(0, 0, 0, 0, 0, 0, 0);
            idle_now = 1'b1;
        end
        vectors++;
        chk("req_ready",  int'(req_ready),  int'(idle_now));
        chk("row_strobe", int'(row_strobe), int'(e.ras));
        chk("col_strobe", int'(col_strobe), int'(e.cas));
        chk("beat_ack",   int'(beat_ack),   int'(e.ack));
        chk("no_resp",    int'(no_resp),    int'(e.nr));
        chk("wr_strobe",  int'(wr_strobe),  int'(e.wr));
        if (e.ras) chk("row_addr", int'(row_addr), e.row);
        if (e.cas) chk("col_addr", int'(col_addr), e.col);
    endtask

    task automatic step();
        if (idle_now && req_valid && rst_n) plan_request();
        @(negedge clk);
        compare();
    endtask

    task automatic issue(string tag, logic [31:0] byte_addr, bit burst, bit wr, logic [2:0] code);
        cur_req   = tag;
        req_addr  = byte_addr[31:2];
        req_burst = burst;
        req_write = wr;
        size_code = code;
        req_valid = 1'b1;
        step();
        req_valid = 1'b0;
        while (!idle_now) step();
        step();
    endtask

    initial begin
        @(negedge clk);
        cur_req = "R1";
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R7 R8 R11: basic read burst, 4 MB
        issue("R8", 32'h2000_0000, 1, 0, 3'd0);
        // R9: start at longword 2, alias of 4 MB at 21000000h
        issue("R9", 32'h2100_0008, 1, 0, 3'd0);
        issue("R9", 32'h2012_345C, 1, 0, 3'd0);
        // R3: blank holes for 4 MB and 8 MB
        issue("R3", 32'h2040_0000, 1, 0, 3'd0);
        issue("R3", 32'h2FC0_0010, 0, 0, 3'd0);
        issue("R3", 32'h2080_0000, 1, 0, 3'd1);
        issue("R3", 32'h207F_FFF4, 1, 0, 3'd1);
        issue("R3", 32'h2E70_0004, 1, 0, 3'd1);
        // R4: larger sizes always hit, aliased modulo size
        issue("R4", 32'h20C0_0004, 1, 0, 3'd2);
        issue("R4", 32'h21C0_0004, 1, 0, 3'd2);
        issue("R4", 32'h2180_0000, 1, 0, 3'd3);
        issue("R4", 32'h23FF_FFFC, 1, 0, 3'd4);
        issue("R4", 32'h2FFF_FFF0, 1, 0, 3'd4);
        // R5: reserved codes
        issue("R5", 32'h2000_0000, 1, 0, 3'd5);
        issue("R5", 32'h2000_0000, 0, 0, 3'd7);
        // R2: outside the window
        issue("R2", 32'h3000_0000, 1, 0, 3'd4);
        issue("R2", 32'h1FFF_FFFC, 0, 0, 3'd4);
        // R6: blank timing
        issue("R6", 32'h2060_0000, 0, 1, 3'd0);
        // R10: single read and single write
        issue("R10", 32'h2000_100C, 0, 0, 3'd2);
        issue("R12", 32'h2000_100C, 0, 1, 3'd2);
        // R12: write burst
        issue("R12", 32'h2034_5678 & 32'hFFFF_FFFC, 1, 1, 3'd3);
        // R13: requests while busy are dropped
        cur_req   = "R13";
        req_addr  = 30'h0800_0001;
        req_burst = 1'b1;
        req_write = 1'b0;
        size_code = 3'd4;
        req_valid = 1'b1;
        step();
        req_addr  = 30'h0800_0100;
        req_write = 1'b1;
        req_burst = 1'b0;
        repeat (6) step();
        req_valid = 1'b0;
        while (!idle_now) step();
        step();
        // R1: reset mid-burst returns to idle
        cur_req   = "R1";
        req_addr  = 30'h0800_0000;
        req_burst = 1'b1;
        req_valid = 1'b1;
        step();
        req_valid = 1'b0;
        step();
        rst_n = 1'b0;
        sched.delete();
        step();
        step();
        rst_n = 1'b1;
        step();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule